// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is the clock-master half of a byte-wide synchronous serial link. It works like a shift register. It moves one byte per transfer over a single bidirectional data line and drives the shift clock on its own output pin. The shift clock comes from the core clock: each bit slot lasts six core clocks, three with the clock low and three with it high. The clock rests high whenever the port is idle. Bits leave and arrive least significant bit first.

Software controls the port through a small word-addressed register bus. Setting the transmit enable and then writing a byte to the transmit buffer starts a send. A single control write that sets both receive enable and start begins a receive. A sticky done flag for each direction raises the interrupt output, and writing ones to the status register clears the flags.

The controller has three states. `ST_IDLE` moves to `ST_TX` when the transmit buffer is written with transmit enabled. It moves to `ST_RX` when a control write carries both receive enable and start. `ST_TX` and `ST_RX` each return to `ST_IDLE` at the end of the last bit slot.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data driver is off (`sdata_oe` low), `irq` is low, and the control, status and receive buffer registers all read zero.
- R2: Register map (`bus_addr`): 0 is control (bit 0 transmit enable, bit 1 receive enable, bit 2 receive start, which is write-only and reads 0). 1 is the transmit buffer. 2 is the receive buffer (read only). 3 is status (bit 0 transmit done, bit 1 receive done, bit 2 busy). A transmit-buffer write made while idle with transmit enable set starts a send: busy and `sdata_oe` are high from the next cycle.
- R3: During a transfer, the shift clock in cycle k after the start edge (k = 0..47) is low when k mod 6 is 2, 3 or 4, and high otherwise. Between transfers it stays high.
- R4: When sending, data bit b is on `sdata_o` from cycle 6b through cycle 6b+5. That is five cycles before the rising edge and one cycle after it. Bits go out in order from bit 0 to bit 7.
- R5: A control write with bits 1 and 2 both set, made while idle, starts a receive. During a receive `sdata_oe` stays low. Bit b is taken from `sdata_i` at the core-clock edge that raises the shift clock for slot b, and the first bit received becomes bit 0.
- R6: 48 cycles after the start edge, busy clears, `sdata_oe` drops and the clock stays high. The matching done flag (status bit 0 for a send, bit 1 for a receive) is set, `irq` goes high, and after a receive the byte is readable at address 2.
- R7: The done flags are sticky. Writing 1 to a status bit clears that flag and writing 0 leaves it unchanged. `irq` is high while either flag is set.
- R8: While busy, a transmit-buffer write leaves the stored byte unchanged, and a receive start has no effect on the transfer in progress.
- R9: A transmit-buffer write with transmit enable clear stores the byte (readable at address 1) but starts no transfer.
- R10: Each transfer produces exactly eight rising edges of the shift clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, high while either done flag is set |
| sclk_o | output | 1 | Shift clock, idles high |
| sdata_o | output | 1 | Serial data out |
| sdata_oe | output | 1 | Serial data driver enable (high only while sending) |
| sdata_i | input | 1 | Serial data in |

## Verification
Timing is counted from the clock edge that samples the starting write, called cycle 0. The clock and data outputs are compared in every cycle from 0 to 47, and the completion results (flags, busy, `irq`, receive buffer) are read in cycle 48. The bench drives inputs on falling edges and reads outputs on falling edges, half a cycle after the register update it expects. Receive data is driven with the wrong bit in every cycle of a slot except the one just before the rising edge, so sampling at any other edge gives a wrong byte. Both directions are swept through all 256 byte values.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } ssp_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_TXB  = 2'd1;
    localparam logic [1:0] REG_RXB  = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int CTL_TXEN  = 0;
    localparam int CTL_RXEN  = 1;
    localparam int CTL_START = 2;

    localparam int STA_TXDONE = 0;
    localparam int STA_RXDONE = 1;
    localparam int STA_BUSY   = 2;

endpackage

// File: rtl/ssp_timing.sv
module ssp_timing #(
    parameter int DATA_W    = 8,
    parameter int SCLK_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic sclk,
    output logic rise_stb,
    output logic slot_end,
    output logic last_slot
);
    localparam int PERIOD = 2 * SCLK_HALF;
    localparam int PH_W   = $clog2(PERIOD);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0]  PH_RISE = PH_W'(PERIOD - 2);
    localparam logic [PH_W-1:0]  PH_LOW0 = PH_W'(SCLK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_END = BIT_W'(DATA_W - 1);

    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  ph_n;
    logic [BIT_W-1:0] bit_q;

    always_comb begin
        ph_n      = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
        slot_end  = run && (ph_q == PH_LAST);
        rise_stb  = run && (ph_q == PH_RISE);
        last_slot = (bit_q == BIT_END);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            bit_q <= '0;
            sclk  <= 1'b1;
        end else if (start) begin
            ph_q  <= '0;
            bit_q <= '0;
            sclk  <= 1'b1;
        end else if (run) begin
            ph_q <= ph_n;
            if (slot_end)
                bit_q <= bit_q + BIT_W'(1);
            sclk <= !((ph_n >= PH_LOW0) && (ph_n <= PH_RISE));
        end else begin
            sclk <= 1'b1;
        end
    end

    // R3: once raised, the clock stays high for at least a second cycle
    assert_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(sclk)) |=> sclk);
    // R3: once lowered, the clock stays low for at least a second cycle
    assert_low_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $fell(sclk)) |=> !sclk);

endmodule

// File: rtl/ssp_shreg.sv
module ssp_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_out,
    input  logic              sample,
    input  logic              sin,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (sample)
            q <= {sin, q[DATA_W-1:1]};
        else if (shift_out)
            q <= {1'b0, q[DATA_W-1:1]};
    end
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              set_tx_done,
    input  logic              set_rx_done,
    input  logic [DATA_W-1:0] rx_cap,
    output logic              tx_en,
    output logic [DATA_W-1:0] txbuf,
    output logic              tx_done,
    output logic              rx_done,
    output logic [DATA_W-1:0] rdata
);
    logic              rx_en;
    logic [DATA_W-1:0] rxbuf;
    logic              wr_ctrl, wr_txb, wr_stat;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
        wr_txb  = bus_wr && (bus_addr == REG_TXB);
        wr_stat = bus_wr && (bus_addr == REG_STAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en   <= 1'b0;
            rx_en   <= 1'b0;
            txbuf   <= '0;
            rxbuf   <= '0;
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                tx_en <= bus_wdata[CTL_TXEN];
                rx_en <= bus_wdata[CTL_RXEN];
            end
            if (wr_txb && !busy)
                txbuf <= bus_wdata;
            if (set_rx_done)
                rxbuf <= rx_cap;
            tx_done <= set_tx_done || (tx_done && !(wr_stat && bus_wdata[STA_TXDONE]));
            rx_done <= set_rx_done || (rx_done && !(wr_stat && bus_wdata[STA_RXDONE]));
        end
    end

    always_comb begin
        rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                rdata[CTL_TXEN] = tx_en;
                rdata[CTL_RXEN] = rx_en;
            end
            REG_TXB:  rdata = txbuf;
            REG_RXB:  rdata = rxbuf;
            REG_STAT: begin
                rdata[STA_TXDONE] = tx_done;
                rdata[STA_RXDONE] = rx_done;
                rdata[STA_BUSY]   = busy;
            end
            default:  rdata = '0;
        endcase
    end

    // R8: a buffer write during a transfer leaves the held byte alone
    assert_txbuf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_txb) |=> $stable(txbuf));
    // R7: a done flag stays set unless a clearing write hits it
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !(wr_stat && bus_wdata[STA_TXDONE])) |=> tx_done);

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SCLK_HALF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sdata_oe,
    input  logic              sdata_i
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    ssp_state_e        state_q, state_n;
    logic              tx_en, tx_done, rx_done;
    logic [DATA_W-1:0] txbuf, sh_q;
    logic              rise_stb, slot_end, last_slot;
    logic              go_tx, go_rx, finish, busy;
    logic              set_tx_done, set_rx_done;

    always_comb begin
        go_tx  = bus_wr && (bus_addr == REG_TXB) && tx_en && (state_q == ST_IDLE);
        go_rx  = bus_wr && (bus_addr == REG_CTRL) && bus_wdata[CTL_RXEN]
                 && bus_wdata[CTL_START] && (state_q == ST_IDLE);
        finish = (state_q != ST_IDLE) && slot_end && last_slot;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_tx)
                    state_n = ST_TX;
                else if (go_rx)
                    state_n = ST_RX;
            end
            ST_TX, ST_RX: begin
                if (finish)
                    state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        sdata_oe    = (state_q == ST_TX);
        sdata_o     = (state_q == ST_TX) ? sh_q[0] : 1'b0;
        set_tx_done = finish && (state_q == ST_TX);
        set_rx_done = finish && (state_q == ST_RX);
        irq         = tx_done || rx_done;
    end

    ssp_timing #(.DATA_W(DATA_W), .SCLK_HALF(SCLK_HALF)) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go_tx || go_rx),
        .run       (busy),
        .sclk      (sclk_o),
        .rise_stb  (rise_stb),
        .slot_end  (slot_end),
        .last_slot (last_slot)
    );

    ssp_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go_tx || go_rx),
        .load_val  (go_tx ? bus_wdata : '0),
        .shift_out ((state_q == ST_TX) && slot_end),
        .sample    ((state_q == ST_RX) && rise_stb),
        .sin       (sdata_i),
        .q         (sh_q)
    );

    ssp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .busy        (busy),
        .set_tx_done (set_tx_done),
        .set_rx_done (set_rx_done),
        .rx_cap      (sh_q),
        .tx_en       (tx_en),
        .txbuf       (txbuf),
        .tx_done     (tx_done),
        .rx_done     (rx_done),
        .rdata       (bus_rdata)
    );

    // checker state: rising edges seen on the clock pin in this transfer
    logic             sclk_d;
    logic [CNT_W-1:0] rise_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (go_tx || go_rx)
                rise_cnt <= '0;
            else if (busy && sclk_o && !sclk_d)
                rise_cnt <= rise_cnt + CNT_W'(1);
        end
    end

    assert_rise_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (rise_cnt == CNT_W'(DATA_W)));
    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> sclk_o);
    assert_tx_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_tx |=> (sdata_oe && sclk_o));
    assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TX) && $rose(sclk_o)) |-> $stable(sdata_o));
    assert_rx_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RX) && $rose(sclk_o)) |-> (sh_q[DATA_W-1] == $past(sdata_i)));
    assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (irq && !sdata_oe && sclk_o));

endmodule

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
    localparam logic [1:0] A_CTRL = 2'd0, A_TXB = 2'd1, A_RXB = 2'd2, A_STAT = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq, sclk, sdo, soe;
    logic       sdi = 1'b0;
    int         nchk = 0;
    int         nfail = 0;
    bit         ended = 1'b0;

    always #2 clk = ~clk;

    sync_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sclk_o(sclk), .sdata_o(sdo), .sdata_oe(soe), .sdata_i(sdi)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        bus_addr = a;
        #1;
        chk(req, "register read", int'(bus_rdata), exp);
    endtask

    function automatic int clk_exp(input int k);
        return ((k % 6) >= 2 && (k % 6) <= 4) ? 0 : 1;
    endfunction

    task automatic tx_run(input logic [7:0] v, input bit inject, input bit clear);
        bus_write(A_TXB, v);
        for (int k = 0; k < 48; k++) begin
            chk("R3", "tx sclk", int'(sclk), clk_exp(k));
            chk("R4", "tx data", int'(sdo), int'(v[k/6]));
            chk("R2", "tx oe", int'(soe), 1);
            if (k == 3) rd_chk("R2", A_STAT, 4);
            bus_wr = 1'b0;
            if (inject && k == 10) begin
                bus_wr = 1'b1; bus_addr = A_TXB; bus_wdata = ~v;
            end
            if (inject && k == 20) begin
                bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 8'h07;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        chk("R6", "tx end sclk", int'(sclk), 1);
        chk("R6", "tx end oe", int'(soe), 0);
        chk("R6", "tx end irq", int'(irq), 1);
        rd_chk("R6", A_STAT, 1);
        rd_chk("R8", A_TXB, int'(v));
        if (clear) begin
            bus_write(A_STAT, 8'h01);
            rd_chk("R7", A_STAT, 0);
            chk("R7", "irq cleared", int'(irq), 0);
        end
    endtask

    task automatic rx_run(input logic [7:0] v, input bit clear, input int stat_exp);
        bus_write(A_CTRL, 8'h06);
        for (int k = 0; k < 48; k++) begin
            chk("R5", "rx oe", int'(soe), 0);
            chk("R3", "rx sclk", int'(sclk), clk_exp(k));
            sdi = ((k % 6) == 4) ? v[k/6] : ~v[k/6];
            @(negedge clk);
        end
        chk("R6", "rx end irq", int'(irq), 1);
        chk("R6", "rx end sclk", int'(sclk), 1);
        rd_chk("R6", A_STAT, stat_exp);
        rd_chk("R5", A_RXB, int'(v));
        if (clear) begin
            bus_write(A_STAT, 8'h02);
            rd_chk("R7", A_STAT, 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!ended) $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset sclk", int'(sclk), 1);
        chk("R1", "reset oe", int'(soe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "irq", int'(irq), 0);
        rd_chk("R1", A_CTRL, 0);
        rd_chk("R1", A_STAT, 0);
        rd_chk("R1", A_RXB, 0);

        // R9 write with transmit disabled
        bus_write(A_TXB, 8'h5A);
        for (int k = 0; k < 8; k++) begin
            chk("R9", "no clock", int'(sclk), 1);
            chk("R9", "no drive", int'(soe), 0);
            @(negedge clk);
        end
        rd_chk("R9", A_STAT, 0);
        rd_chk("R9", A_TXB, 8'h5A);

        // R2 R3 R4 R6: every transmit byte
        bus_write(A_CTRL, 8'h01);
        rd_chk("R2", A_CTRL, 1);
        for (int v = 0; v < 256; v++) tx_run(8'(v), 1'b0, 1'b1);

        // R8 writes during a send are ignored
        tx_run(8'hA5, 1'b1, 1'b1);
        tx_run(8'h96, 1'b1, 1'b1);

        // R5 R6: every receive byte
        for (int v = 0; v < 256; v++) rx_run(8'(v), 1'b1, 2);

        // R7 partial clearing
        bus_write(A_CTRL, 8'h01);
        tx_run(8'h3C, 1'b0, 1'b0);
        rx_run(8'hC3, 1'b0, 3);
        bus_write(A_STAT, 8'h02);
        rd_chk("R7", A_STAT, 1);
        chk("R7", "irq one flag", int'(irq), 1);
        bus_write(A_STAT, 8'h00);
        rd_chk("R7", A_STAT, 1);
        bus_write(A_STAT, 8'h01);
        rd_chk("R7", A_STAT, 0);
        chk("R7", "irq none", int'(irq), 0);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule